// File: doc/BRIEF.md
# Split Isochronous Transaction Sequencer

This block decides, micro-frame by micro-frame, whether a full-speed isochronous IN endpoint that sits behind a high-speed hub receives a start-split, a complete-split, or no transaction at all. It keeps two descriptor contexts: the one for the frame now being walked (current) and the one from the frame before (previous). Each context carries an eight-bit start mask, an eight-bit completion mask, a one-bit split phase (0 = start phase, 1 = completion phase), an active flag, and a flag saying whether its link to the earlier descriptor is usable.

The hard case is a completion schedule that wraps past the end of a frame. Completion slots at the start of the new frame belong to the transaction that began in the old frame. The block then points the complete-split at the previous context. When that transaction retires, the block hands the start phase to the current context, so the current context can issue its own start-split later in the frame.

A frame strobe moves the current context into the previous slot and loads a fresh current context from the load ports. A micro-frame tick with its index asks the block to decide for that slot. The response port carries the outcome of each complete-split. Bus signalling, descriptor fetch and data movement are handled elsewhere.

Top module: `split_iso_seq`

## Requirements
- R1: After reset, no request or writeback strobe is high, the current context is inactive and in the start phase (`cur_cs` = 0), and the previous context is inactive.
- R2: A tick in micro-frame u, where the current context is active, in the start phase, and has bit u of its start mask set, gives a one-cycle `req_ss` pulse on the next clock with `ctx_prev` = 0. The split phase becomes 1 in the same cycle.
- R3: In the start phase the completion mask is ignored. A tick in a micro-frame with no start-mask bit set produces no request.
- R4: After the current context has issued its start-split in this frame, each tick in a micro-frame whose completion-mask bit is set, while the context is still active and in the completion phase, gives a `req_cs` pulse with `ctx_prev` = 0. `req_ss` and `req_cs` are never high together.
- R5: A completion-mask tick while the current context is in the completion phase and has not started this frame counts as a wrap slot. If the start-mask bit for that slot is clear, the link flag is set and the previous context is active, the tick gives `req_cs` with `ctx_prev` = 1. `ctx_prev` stays high until the response arrives.
- R6: Response code 2 (DATA0) to a complete-split aimed at the previous context pulses both `wb_prev` and `wb_cur`, clears `prev_active`, and sets `cur_cs` to 0.
- R7: Response code 1 (MDATA) pulses the writeback strobe of the targeted context only, and leaves every active flag and the split phase unchanged. `ctx_prev` returns to 0.
- R8: DATA0 to a complete-split aimed at the current context pulses `wb_cur`, clears `cur_active`, and sets `cur_cs` to 0. The remaining completion slots of the frame then issue nothing.
- R9: Once the previous context has retired, later wrap slots in the same frame issue nothing for it.
- R10: Response code 0 or 3 (no response / timeout) pulses no strobe and changes no state. The next scheduled completion slot issues the same request again.
- R11: A frame strobe copies the current active flag into `prev_active` and loads the current context from the load ports, including its initial split phase from `ld_cs`.
- R12: A wrap slot whose link flag is clear, or whose previous context is inactive, issues nothing and sets `cur_cs` to 0, so that a later start-mask slot can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame strobe: shift contexts and load a new current context |
| ld_smask | input | 8 | Start mask for the incoming context |
| ld_cmask | input | 8 | Completion mask for the incoming context |
| ld_cs | input | 1 | Initial split phase of the incoming context (1 = completion) |
| ld_active | input | 1 | Active flag of the incoming context |
| ld_link_ok | input | 1 | Link to the previous descriptor is usable |
| uframe_tick | input | 1 | Evaluate the micro-frame given by `uframe_idx` |
| uframe_idx | input | 3 | Micro-frame index 0..7 |
| rsp_valid | input | 1 | Response to the outstanding complete-split |
| rsp_code | input | 2 | 0 none, 1 MDATA, 2 DATA0, 3 timeout |
| req_ss | output | 1 | Issue a start-split |
| req_cs | output | 1 | Issue a complete-split |
| ctx_prev | output | 1 | Outstanding complete-split uses the previous context |
| wb_prev | output | 1 | Write back the previous descriptor |
| wb_cur | output | 1 | Write back the current descriptor |
| cur_cs | output | 1 | Split phase of the current context |
| cur_active | output | 1 | Active flag of the current context |
| prev_active | output | 1 | Active flag of the previous context |

## Verification
The assertions assume that the frame strobe, micro-frame ticks and responses never share a cycle. They also assume that a response arrives only while a complete-split is outstanding, and that no tick arrives before that response. The bench serializes its stimulus to honour these rules: it sends one event per cycle and waits for each issued complete-split's response, with a random delay, before the next tick. Random masks, link flags, initial phases and response codes exercise the wrap path and early retirement. Directed frames cover the wrapped schedule with masks 0x10 and 0xC3.

// File: rtl/split_iso_seq.sv
module split_iso_seq #(
  parameter int UF = 8,
  parameter int UW = $clog2(UF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [UF-1:0] ld_smask,
  input  logic [UF-1:0] ld_cmask,
  input  logic          ld_cs,
  input  logic          ld_active,
  input  logic          ld_link_ok,
  input  logic          uframe_tick,
  input  logic [UW-1:0] uframe_idx,
  input  logic          rsp_valid,
  input  logic [1:0]    rsp_code,
  output logic          req_ss,
  output logic          req_cs,
  output logic          ctx_prev,
  output logic          wb_prev,
  output logic          wb_cur,
  output logic          cur_cs,
  output logic          cur_active,
  output logic          prev_active
);
  localparam logic [1:0] RSP_MDATA = 2'd1;
  localparam logic [1:0] RSP_DATA0 = 2'd2;

  logic [UF-1:0] c_sm, c_cm;
  logic          c_link, c_started, pending;

  wire s_hit    = c_sm[uframe_idx];
  wire c_hit    = c_cm[uframe_idx];
  wire go       = uframe_tick && !pending && !frame_start;
  wire do_ss    = go && cur_active && s_hit && !cur_cs;
  wire cs_slot  = go && c_hit && cur_cs;
  wire own_cs   = cs_slot && c_started && cur_active;
  wire wrap_ok  = !s_hit && c_link && prev_active;
  wire wrap_cs  = cs_slot && !c_started && wrap_ok;
  wire handover = cs_slot && !c_started && !wrap_ok;
  wire got      = pending && rsp_valid && !frame_start;
  wire is_d0    = rsp_code == RSP_DATA0;
  wire is_md    = rsp_code == RSP_MDATA;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ss <= 1'b0; req_cs <= 1'b0; ctx_prev <= 1'b0;
      wb_prev <= 1'b0; wb_cur <= 1'b0;
      cur_cs <= 1'b0; cur_active <= 1'b0; prev_active <= 1'b0;
      c_sm <= '0; c_cm <= '0; c_link <= 1'b0; c_started <= 1'b0;
      pending <= 1'b0;
    end else begin
      req_ss  <= do_ss;
      req_cs  <= own_cs || wrap_cs;
      wb_prev <= got && ctx_prev && (is_d0 || is_md);
      wb_cur  <= got && (ctx_prev ? is_d0 : (is_d0 || is_md));
      if (frame_start) begin
        prev_active <= cur_active;
        c_sm        <= ld_smask;
        c_cm        <= ld_cmask;
        cur_cs      <= ld_cs;
        cur_active  <= ld_active;
        c_link      <= ld_link_ok;
        c_started   <= 1'b0;
        pending     <= 1'b0;
        ctx_prev    <= 1'b0;
      end else if (got) begin
        pending  <= 1'b0;
        ctx_prev <= 1'b0;
        if (is_d0) begin
          if (ctx_prev) prev_active <= 1'b0;
          else          cur_active  <= 1'b0;
          cur_cs <= 1'b0;
        end
      end else begin
        if (do_ss) begin
          cur_cs    <= 1'b1;
          c_started <= 1'b1;
        end
        if (own_cs || wrap_cs) begin
          pending  <= 1'b1;
          ctx_prev <= wrap_cs;
        end
        if (handover) cur_cs <= 1'b0;
      end
    end
  end

  assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ss && req_cs));

  assert_ss_enters_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ss |-> cur_cs && !ctx_prev);

  assert_wrap_needs_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctx_prev) |-> prev_active && req_cs);

  assert_wb_prev_targets_prev_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_prev |-> $past(ctx_prev) && !ctx_prev);

  assert_retire_writes_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(prev_active) && !$past(frame_start)) |-> (wb_prev && wb_cur && !cur_cs));

  assert_cur_retire_writes_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cur_active) && !$past(frame_start)) |-> (wb_cur && !wb_prev));
endmodule

// File: tb/split_iso_seq_test.sv
module split_iso_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, ld_cs = 0, ld_active = 0, ld_link_ok = 0;
  logic [7:0] ld_smask = 0, ld_cmask = 0;
  logic uframe_tick = 0, rsp_valid = 0;
  logic [2:0] uframe_idx = 0;
  logic [1:0] rsp_code = 0;
  logic req_ss, req_cs, ctx_prev, wb_prev, wb_cur, cur_cs, cur_active, prev_active;

  always #5 clk = ~clk;

  split_iso_seq uut (.*);

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // reference model
  bit m_cs, m_act, m_link, m_started, p_act;
  logic [7:0] m_sm, m_cm;

  task automatic chk(string r, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  // 0 none, 1 start-split, 2 complete-split current, 3 complete-split previous
  function automatic int predict(int u);
    if (m_act && m_sm[u] && !m_cs) return 1;
    if (m_cm[u] && m_cs) begin
      if (m_started) return m_act ? 2 : 0;
      if (!m_sm[u] && m_link && p_act) return 3;
      return 4;
    end
    return 0;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R12";
      default: return "R3";
    endcase
  endfunction

  task automatic load(bit [7:0] sm, bit [7:0] cm, bit cs, bit act, bit link);
    @(negedge clk);
    frame_start = 1; ld_smask = sm; ld_cmask = cm; ld_cs = cs;
    ld_active = act; ld_link_ok = link;
    @(negedge clk);
    frame_start = 0;
    p_act = m_act; m_sm = sm; m_cm = cm; m_cs = cs; m_act = act;
    m_link = link; m_started = 0;
    chk("R11", "cur_cs", cur_cs, m_cs);
    chk("R11", "cur_active", cur_active, m_act);
    chk("R11", "prev_active", prev_active, p_act);
  endtask

  task automatic tick(int u, int code, int dly, string rt = "");
    int k;
    bit exp_wp, exp_wc, tgt_prev;
    string t;
    k = predict(u);
    t = (rt != "") ? rt : tag_of(k);
    @(negedge clk);
    uframe_tick = 1; uframe_idx = 3'(u);
    @(negedge clk);
    uframe_tick = 0;
    if (k == 1) begin m_cs = 1; m_started = 1; end
    if (k == 4) m_cs = 0;
    chk(t, "req_ss", req_ss, k == 1);
    chk(t, "req_cs", req_cs, k == 2 || k == 3);
    chk(t, "ctx_prev", ctx_prev, k == 3);
    chk(t, "cur_cs", cur_cs, m_cs);
    if (k == 2 || k == 3) begin
      tgt_prev = (k == 3);
      repeat (dly) begin
        @(negedge clk);
        chk("R5", "ctx_prev held", ctx_prev, tgt_prev);
      end
      @(negedge clk);
      rsp_valid = 1; rsp_code = 2'(code);
      @(negedge clk);
      rsp_valid = 0;
      exp_wp = tgt_prev && (code == 1 || code == 2);
      exp_wc = (code == 2) || (!tgt_prev && code == 1);
      if (code == 2) begin
        if (tgt_prev) p_act = 0; else m_act = 0;
        m_cs = 0;
      end
      t = (code == 2) ? (tgt_prev ? "R6" : "R8") : (code == 1 ? "R7" : "R10");
      chk(t, "wb_prev", wb_prev, exp_wp);
      chk(t, "wb_cur", wb_cur, exp_wc);
      chk(t, "ctx_prev after", ctx_prev, 0);
      chk(t, "prev_active", prev_active, p_act);
      chk(t, "cur_active", cur_active, m_act);
      chk(t, "cur_cs", cur_cs, m_cs);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_cs = 0; m_act = 0; m_link = 0; m_started = 0; p_act = 0; m_sm = 0; m_cm = 0;
    repeat (3) @(negedge clk);
    chk("R1", "req_ss", req_ss, 0);
    chk("R1", "req_cs", req_cs, 0);
    chk("R1", "wb", wb_prev | wb_cur, 0);
    chk("R1", "cur_cs", cur_cs, 0);
    chk("R1", "active", cur_active | prev_active, 0);
    rst_n = 1;

    // directed wrapped schedule
    load(8'h10, 8'hC3, 0, 1, 0);
    tick(0, 0, 0, "R3"); tick(1, 0, 0, "R3");
    tick(4, 0, 0); tick(6, 1, 1); tick(7, 0, 0);
    load(8'h10, 8'hC3, 1, 1, 1);
    tick(0, 0, 2, "R10"); tick(0, 2, 0);
    tick(1, 0, 0, "R9");
    tick(4, 0, 0); tick(6, 2, 0); tick(7, 0, 0, "R8");
    load(8'h10, 8'hC3, 1, 1, 1);
    tick(0, 0, 0, "R12"); tick(4, 0, 0); tick(6, 3, 0); tick(7, 1, 0);
    load(8'h10, 8'hC3, 1, 1, 1);
    tick(0, 1, 0, "R7"); tick(1, 1, 0, "R7");
    load(8'h10, 8'hC3, 1, 1, 0);
    tick(0, 0, 0, "R12"); tick(4, 0, 0);

    // constrained random frames
    for (int f = 0; f < 300; f++) begin
      bit [7:0] sm, cm;
      int s;
      s = 2 + int'($urandom_range(3));
      sm = 8'(1 << s);
      cm = 8'($urandom) & ~sm;
      load(sm, cm, 1'($urandom_range(1)), $urandom_range(7) != 0,
           $urandom_range(5) != 0);
      for (int u = 0; u < 8; u++) begin
        int c;
        c = int'($urandom_range(3));
        tick(u, c, int'($urandom_range(2)));
        if ($urandom_range(3) == 0) tick(u, int'($urandom_range(3)), 0);
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule